// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter Stage

This block is a four-bit up-counter whose state bits all change together on the rising clock edge. There is no ripple clocking between the bits. Each edge performs exactly one operation, picked by priority from the control inputs. A low clear zeroes the count. A low load copies a four-bit preset word into the count. When both enables are high the count steps by one. In every other case the count holds.

Two elaboration parameters choose the variant. One selects binary counting (modulo 16) or decade counting (modulo 10). The other selects a clear that acts at the next edge or a clear that acts at once.

A combinational carry output goes high when the count sits at its terminal value (15 in binary, 9 in decade) and the trickle enable is high. The parallel enable does not affect the carry. To build a wider synchronous counter, drive each stage's trickle enable from the previous stage's carry and run all stages from one clock. With the edge-timed clear, decoding a count N and feeding the decode back into clear gives a shortened cycle of N+1 states.

The operation chosen on each edge is an enumerated state:

| State | Condition |
|-------|-----------|
| OP_CLEAR | clear low |
| OP_LOAD | load low |
| OP_COUNT | both enables high |
| OP_HOLD | anything else |

The next edge follows these transitions:

| From state | Next count |
|------------|------------|
| OP_CLEAR | 0 |
| OP_LOAD | the preset word |
| OP_COUNT | the count plus one, wrapping at the terminal value |
| OP_HOLD | the count unchanged |

Top module: `sync_count_stage`

## Requirements
- R1: With clear and load high and both enables high, each rising edge raises the count by one.
- R2: With clear and load high and either enable low, the count keeps its value across the edge.
- R3: A low load copies din into the count at the next edge, whatever the enable levels.
- R4: With ASYNC_CLR=0, a low clear gives count 0 at the next edge, overriding load and both enables.
- R5: With ASYNC_CLR=1, a low clear forces the count to 0 before any clock edge and keeps it there while clear stays low.
- R6: carry is 1 exactly when en_t is 1 and the count equals the terminal value (15 binary, 9 decade); en_p has no effect on carry.
- R7: With DECADE=0, counting from 15 gives 0.
- R8: With DECADE=1, the count runs 0,1,...,9 and then 0.
- R9: With DECADE=1, counting from any loaded value 10 to 15 gives 0 at the next counting edge.
- R10: Two stages with the low stage's carry driving the high stage's en_t behave as one eight-bit counter; the high stage advances exactly on the edge where the low stage wraps.
- R11: With ASYNC_CLR=0, feeding back "count equals N" as an active-low clear gives a repeating cycle 0..N of length N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, edge-timed or immediate per ASYNC_CLR |
| load_n | input | 1 | Active-low synchronous preset |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable, also qualifies carry |
| din | input | W | Preset word |
| q | output | W | Current count |
| carry | output | 1 | Terminal-count carry for cascading |

## Verification
The block has no reset apart from its own clear. The checker therefore assumes that clear is pulsed low at a clock edge before any property is evaluated. It stays idle until it has seen such an edge.

The checker also assumes that an immediate clear is held low through the next edge once it has been asserted between edges. Inputs are assumed to change only between edges.

The bench meets these assumptions in the following way. It drives every control on the falling clock edge. It opens each instance's run with a clear. It drops the immediate clear only in mid-cycle and keeps it low past the following edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_t;

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_t op
);

    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_p && en_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_next_value.sv
module cnt_next_value
    import cnt_pkg::*;
#(
    parameter int unsigned W      = 4,
    parameter bit          DECADE = 1'b0
) (
    input  cnt_op_t      op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] TERM = DECADE ? W'(9) : {W{1'b1}};

    logic [W-1:0] stepped;

    // Any value at or beyond the terminal value wraps to zero.
    always_comb begin
        if (cur >= TERM)
            stepped = '0;
        else
            stepped = cur + W'(1);
    end

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = stepped;
            OP_HOLD:  nxt = cur;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
    parameter int unsigned W      = 4,
    parameter bit          DECADE = 1'b0
) (
    input  logic [W-1:0] cur,
    input  logic         en_t,
    output logic         carry
);

    localparam logic [W-1:0] TERM = DECADE ? W'(9) : {W{1'b1}};

    assign carry = en_t && (cur == TERM);

endmodule

// File: rtl/sync_count_stage.sv
module sync_count_stage
    import cnt_pkg::*;
#(
    parameter int unsigned W         = 4,
    parameter bit          DECADE    = 1'b0,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         carry
);

    cnt_op_t      op;
    logic [W-1:0] cnt_r;
    logic [W-1:0] cnt_nxt;

    cnt_op_decode u_dec (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    cnt_next_value #(.W(W), .DECADE(DECADE)) u_nxt (
        .op  (op),
        .cur (cnt_r),
        .din (din),
        .nxt (cnt_nxt)
    );

    cnt_carry #(.W(W), .DECADE(DECADE)) u_cry (
        .cur   (cnt_r),
        .en_t  (en_t),
        .carry (carry)
    );

    generate
        if (ASYNC_CLR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    cnt_r <= '0;
                else
                    cnt_r <= cnt_nxt;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                cnt_r <= cnt_nxt;
            end
        end
    endgenerate

    assign q = cnt_r;

endmodule

// File: rtl/sync_count_stage_chk.sv
module sync_count_stage_chk #(
    parameter int unsigned W         = 4,
    parameter bit          DECADE    = 1'b0,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_n,
    input logic         en_p,
    input logic         en_t,
    input logic [W-1:0] din,
    input logic [W-1:0] q,
    input logic         carry
);

    localparam logic [W-1:0] TERM = DECADE ? W'(9) : {W{1'b1}};

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (!clr_n)
            armed <= 1'b1;
    end

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && en_p && en_t) |=>
        ((ASYNC_CLR && !clr_n) ||
         q == (($past(q) >= TERM) ? W'(0) : W'($past(q) + W'(1)))));

    // R2
    hold_value_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && !(en_p && en_t)) |=>
        ((ASYNC_CLR && !clr_n) || $stable(q)));

    // R3
    load_copy_chk: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !load_n) |=> ((ASYNC_CLR && !clr_n) || q == $past(din)));

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!armed)
        (!clr_n) |=> (q == '0));

    generate
        if (ASYNC_CLR) begin : g_async_chk
            // R5
            async_clear_chk: assert property (@(posedge clk) disable iff (!armed)
                (!clr_n) |-> (q == '0));
        end
    endgenerate

    // R6
    carry_match_chk: assert property (@(posedge clk) disable iff (!armed)
        carry == (en_t && q == TERM));

endmodule

bind sync_count_stage sync_count_stage_chk #(
    .W(W), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) chk_i (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .din    (din),
    .q      (q),
    .carry  (carry)
);

// File: tb/sync_count_stage_tb_top.sv
module sync_count_stage_tb_top;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Binary, edge-timed clear.
    logic       b_clr_n = 1'b1, b_load_n = 1'b1, b_p = 1'b0, b_t = 1'b0;
    logic [3:0] b_din = '0, b_q;
    logic       b_cry;
    sync_count_stage #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) dut_i (
        .clk(clk), .clr_n(b_clr_n), .load_n(b_load_n), .en_p(b_p), .en_t(b_t),
        .din(b_din), .q(b_q), .carry(b_cry));

    // Decade, immediate clear.
    logic       d_clr_n = 1'b1, d_load_n = 1'b1, d_p = 1'b0, d_t = 1'b0;
    logic [3:0] d_din = '0, d_q;
    logic       d_cry;
    sync_count_stage #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) dut_dec (
        .clk(clk), .clr_n(d_clr_n), .load_n(d_load_n), .en_p(d_p), .en_t(d_t),
        .din(d_din), .q(d_q), .carry(d_cry));

    // Truncated cycle: clear fed back from a decode of count 5.
    logic       tr_go = 1'b0;
    logic [3:0] tr_q;
    logic       tr_cry, tr_clr_n;
    assign tr_clr_n = tr_go && (tr_q != 4'd5);
    sync_count_stage #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) dut_tr (
        .clk(clk), .clr_n(tr_clr_n), .load_n(1'b1), .en_p(1'b1), .en_t(1'b1),
        .din(4'd0), .q(tr_q), .carry(tr_cry));

    // Two-stage cascade.
    logic       c_clr_n = 1'b1, c_en = 1'b0;
    logic [3:0] lo_q, hi_q;
    logic       lo_cry, hi_cry;
    sync_count_stage #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) dut_lo (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_p(1'b1), .en_t(c_en),
        .din(4'd0), .q(lo_q), .carry(lo_cry));
    sync_count_stage #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) dut_hi (
        .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_p(1'b1), .en_t(lo_cry),
        .din(4'd0), .q(hi_q), .carry(hi_cry));

    // Vector: {clr_n, load_n, en_p, en_t, din[3:0], exp_q[3:0], exp_carry}
    localparam int NV = 12;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 1'b1, 4'd5,  4'd0,  1'b0},  // R4 clear beats enables
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd13, 4'd13, 1'b0},  // R3 load with enables low
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b0},  // R1
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1},  // R1 R6
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R7 wrap
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd0,  1'b0},  // R2 P low
        {1'b1, 1'b0, 1'b0, 1'b1, 4'd15, 4'd15, 1'b1},  // R6 carry with P low
        {1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  4'd15, 1'b0},  // R2 R6
        {1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  4'd15, 1'b0},  // R2 T low
        {1'b0, 1'b0, 1'b1, 1'b1, 4'd7,  4'd0,  1'b0},  // R4 clear beats load
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd9,  4'd9,  1'b0},  // R3 load beats enables
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd10, 1'b0}   // R1
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);

        // Table walk on the binary stage.
        for (int i = 0; i < NV; i++) begin
            {b_clr_n, b_load_n, b_p, b_t, b_din} = VEC[i][12:5];
            step();
            check($sformatf("R1-table q vec %0d", i), b_q, VEC[i][4:1]);
            check($sformatf("R6 carry vec %0d", i), b_cry, VEC[i][0]);
        end

        // Decade, immediate clear.
        d_clr_n = 1'b0;
        d_p = 1'b1;
        d_t = 1'b1;
        step();
        d_clr_n = 1'b1;
        check("R5 clear state", d_q, 0);
        for (int k = 1; k <= 9; k++) begin
            step();
            check("R8 decade count", d_q, k);
        end
        check("R6 decade carry at 9", d_cry, 1);
        d_p = 1'b0;
        #1;
        check("R6 decade carry P low", d_cry, 1);
        d_p = 1'b1;
        step();
        check("R8 decade wrap", d_q, 0);
        check("R6 decade carry off", d_cry, 0);

        d_load_n = 1'b0;
        d_din = 4'd12;
        step();
        check("R3 decade load 12", d_q, 12);
        d_load_n = 1'b1;
        step();
        check("R9 from 12", d_q, 0);
        d_load_n = 1'b0;
        d_din = 4'd15;
        step();
        d_load_n = 1'b1;
        check("R6 no carry at 15 decade", d_cry, 0);
        step();
        check("R9 from 15", d_q, 0);

        step();
        step();
        step();
        check("R8 decade at 3", d_q, 3);
        #2;
        d_clr_n = 1'b0;
        #1;
        check("R5 immediate clear", d_q, 0);
        @(negedge clk);
        check("R5 clear held", d_q, 0);
        d_clr_n = 1'b1;
        step();
        check("R1 after immediate clear", d_q, 1);

        // Truncated cycle via clear feedback.
        step();
        check("R11 initial clear", tr_q, 0);
        tr_go = 1'b1;
        for (int k = 1; k <= 13; k++) begin
            step();
            check("R11 truncated cycle", tr_q, k % 6);
        end

        // Cascade.
        c_clr_n = 1'b0;
        step();
        c_clr_n = 1'b1;
        c_en = 1'b1;
        for (int k = 1; k <= 255; k++) begin
            step();
            if (k == 15 || k == 16 || k == 100 || k == 255)
                check($sformatf("R10 cascade value at %0d", k), {hi_q, lo_q}, k);
            if (k == 15)
                check("R10 low carry", lo_cry, 1);
        end
        check("R10 high carry at 255", hi_cry, 1);
        step();
        check("R10 cascade wrap", {hi_q, lo_q}, 0);

        finish_run();
    end

endmodule